// File: doc/BRIEF.md
# Oscillator Pull-Word Frame Sequencer

This block turns one digital pull request for a controlled oscillator into the serial frames that carry it. A request holds a two's-complement control value, a resolution select and a 4-bit device address. The block assembles each 40-bit frame from three parts: a fixed header with the device address inside it, a target register address, and a 16-bit data word. It presents each frame to a bit-level line driver over a valid/ready handshake. After each accepted frame it holds the line quiet for a programmable number of clock cycles.

In narrow mode, a request yields a single frame to register 0x06 carrying the low 16 bits of the value. In wide mode, the value is 23 bits wide and is sent as two frames. The first frame goes to register 0x07 and holds the seven least significant bits, zero-padded to 16 bits. The second frame goes to register 0x06 and holds the upper sixteen bits. Because the oscillator applies a new frequency only when register 0x06 is written, a wide update takes effect on its second frame.

The block accepts a new request only when it is idle. It holds off requests through its ready output while any frame or gap is still outstanding. Converting a ppm offset into a control value is done outside the block.

Top module: `dcxo_update_seq`

## Requirements
- R1: After reset, frmValid and busy are low and reqReady is high.
- R2: Every frame on frmData has this layout: bits [39:32] = 0xFA, bits [31:28] = the captured device address, bits [27:24] = 0xA, bits [23:16] = register address, bits [15:0] = data word. Bit 39 is the first bit on the wire.
- R3: In narrow mode (reqWide = 0), one frame is produced, to register 0x06, with data = reqValue[15:0]. Bits reqValue[22:16] have no effect.
- R4: In wide mode (reqWide = 1), exactly two frames are produced. The first goes to register 0x07 with data {9'b0, reqValue[6:0]}. The second goes to register 0x06 with data reqValue[22:7]. For example, 0x09CF8A gives 0x000A, then 0x139F.
- R5: While frmValid is high and frmReady is low, frmValid stays high and frmData does not change.
- R6: After each accepted frame, frmValid stays low and busy stays high for exactly the captured gap count of cycles. A gap count of 0 inserts no idle cycle. After the last frame's gap, busy falls.
- R7: reqReady is high only when busy is low. A request while reqReady is low is not taken, and it does not change the frames of the update in progress.
- R8: The value, mode, device address and gap count are captured when a request is accepted. Later changes to these inputs have no effect on the update in progress.
- R9: frmValid rises in the first cycle after the clock edge that accepts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Update request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqWide | input | 1 | 1 = two-frame 23-bit update, 0 = one-frame 16-bit update |
| reqValue | input | VAL_W (23) | Two's-complement control value |
| devAddr | input | 4 | Device address placed in the header |
| gapCycles | input | GAP_W (16) | Idle cycles after each accepted frame |
| frmValid | output | 1 | Frame available for the line driver |
| frmReady | input | 1 | Line driver takes the frame |
| frmData | output | 40 | Frame, most significant bit sent first |
| busy | output | 1 | Update or gap in progress |

## Verification
The checker watches several properties on every cycle:
- the fixed header nibbles and the legal register addresses;
- zero padding in the fine word;
- frame stability under back-pressure;
- ordering, so that register 0x07 is always followed by register 0x06;
- the exact idle-cycle count against the gap captured at acceptance;
- the rule that ready and busy never overlap.

Whether the data words are the correct slices of the requested value, and whether the device address reaches the header, can only be shown by the bench's scenarios. The bench compares against frames computed from the request. Its scenarios cover the two worked values, a negative value, zero gaps, random stalls, and junk requests issued during busy periods.

// File: rtl/dcxo_seq_pkg.sv
package dcxo_seq_pkg;
  localparam int HDR_W   = 16;
  localparam int ADR_W   = 8;
  localparam int WORD_W  = 16;
  localparam int FRAME_W = HDR_W + ADR_W + WORD_W;

  localparam logic [7:0] HDR_TOP  = 8'hFA;
  localparam logic [3:0] HDR_TAIL = 4'hA;
  localparam logic [ADR_W-1:0] REG_COARSE = 8'h06;
  localparam logic [ADR_W-1:0] REG_FINE   = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FINE,
    ST_COARSE,
    ST_GAP_MID,
    ST_GAP_END
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic sendFine;
    logic loadGap;
    logic stepGap;
  } dpStrobe_t;
endpackage

// File: rtl/dcxo_seq_dp.sv
module dcxo_seq_dp
  import dcxo_seq_pkg::*;
#(
  parameter int VAL_W = 23,
  parameter int GAP_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               reqWide,
  input  logic [VAL_W-1:0]   reqValue,
  input  logic [3:0]         devAddr,
  input  logic [GAP_W-1:0]   gapCycles,
  output logic [FRAME_W-1:0] frmData,
  output logic               gapZero,
  output logic               gapLast
);
  localparam int FINE_W = VAL_W - WORD_W;
  localparam int PAD_W  = WORD_W - FINE_W;

  logic [VAL_W-1:0] valueQ;
  logic             wideQ;
  logic [3:0]       devQ;
  logic [GAP_W-1:0] gapQ;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueQ <= '0;
      wideQ  <= 1'b0;
      devQ   <= '0;
      gapQ   <= '0;
    end else if (strobe.capture) begin
      valueQ <= reqValue;
      wideQ  <= reqWide;
      devQ   <= devAddr;
      gapQ   <= gapCycles;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.loadGap) begin
      gapCnt <= gapQ;
    end else if (strobe.stepGap && gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  assign gapZero = (gapQ == '0);
  assign gapLast = (gapCnt <= GAP_W'(1));

  logic [ADR_W-1:0]  regSel;
  logic [WORD_W-1:0] wordSel;

  always_comb begin
    if (strobe.sendFine) begin
      regSel  = REG_FINE;
      wordSel = {{PAD_W{1'b0}}, valueQ[FINE_W-1:0]};
    end else if (wideQ) begin
      regSel  = REG_COARSE;
      wordSel = valueQ[VAL_W-1:FINE_W];
    end else begin
      regSel  = REG_COARSE;
      wordSel = valueQ[WORD_W-1:0];
    end
  end

  assign frmData = {HDR_TOP, devQ, HDR_TAIL, regSel, wordSel};
endmodule

// File: rtl/dcxo_seq_ctrl.sv
module dcxo_seq_ctrl
  import dcxo_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWide,
  input  logic      frmReady,
  input  logic      gapZero,
  input  logic      gapLast,
  output logic      reqReady,
  output logic      frmValid,
  output logic      busy,
  output dpStrobe_t strobe
);
  seqState_t state, stateNxt;

  logic idle, accept, sent;

  assign idle   = (state == ST_IDLE);
  assign accept = idle && reqValid;
  assign sent   = frmValid && frmReady;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:    if (accept) stateNxt = reqWide ? ST_FINE : ST_COARSE;
      ST_FINE:    if (frmReady) stateNxt = gapZero ? ST_COARSE : ST_GAP_MID;
      ST_COARSE:  if (frmReady) stateNxt = gapZero ? ST_IDLE : ST_GAP_END;
      ST_GAP_MID: if (gapLast) stateNxt = ST_COARSE;
      ST_GAP_END: if (gapLast) stateNxt = ST_IDLE;
      default:    stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady = idle;
  assign busy     = !idle;
  assign frmValid = (state == ST_FINE) || (state == ST_COARSE);

  always_comb begin
    strobe          = '0;
    strobe.capture  = accept;
    strobe.sendFine = (state == ST_FINE);
    strobe.loadGap  = sent && !gapZero;
    strobe.stepGap  = (state == ST_GAP_MID) || (state == ST_GAP_END);
  end
endmodule

// File: rtl/dcxo_update_seq.sv
module dcxo_update_seq
  import dcxo_seq_pkg::*;
#(
  parameter int VAL_W = 23,
  parameter int GAP_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic               reqWide,
  input  logic [VAL_W-1:0]   reqValue,
  input  logic [3:0]         devAddr,
  input  logic [GAP_W-1:0]   gapCycles,
  output logic               frmValid,
  input  logic               frmReady,
  output logic [FRAME_W-1:0] frmData,
  output logic               busy
);
  dpStrobe_t strobe;
  logic gapZero, gapLast;

  dcxo_seq_ctrl ctrlInst (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWide  (reqWide),
    .frmReady (frmReady),
    .gapZero  (gapZero),
    .gapLast  (gapLast),
    .reqReady (reqReady),
    .frmValid (frmValid),
    .busy     (busy),
    .strobe   (strobe)
  );

  dcxo_seq_dp #(.VAL_W(VAL_W), .GAP_W(GAP_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqWide   (reqWide),
    .reqValue  (reqValue),
    .devAddr   (devAddr),
    .gapCycles (gapCycles),
    .frmData   (frmData),
    .gapZero   (gapZero),
    .gapLast   (gapLast)
  );
endmodule

// File: rtl/dcxo_seq_chk.sv
module dcxo_seq_chk #(
  parameter int GAP_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [GAP_W-1:0] gapCycles,
  input logic             frmValid,
  input logic             frmReady,
  input logic [39:0]      frmData,
  input logic             busy
);
  logic [GAP_W-1:0] gapSeen;
  logic [GAP_W:0]   idleCnt;
  logic             finePending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapSeen     <= '0;
      idleCnt     <= '0;
      finePending <= 1'b0;
    end else begin
      if (reqValid && reqReady) gapSeen <= gapCycles;
      if (frmValid && frmReady) idleCnt <= '0;
      else if (busy && !frmValid) idleCnt <= idleCnt + 1'b1;
      if (frmValid && frmReady) finePending <= (frmData[23:16] == 8'h07);
    end
  end

  AST_HEADER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmData[39:32] == 8'hFA && frmData[27:24] == 4'hA)); // R2
  AST_REG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> (frmData[23:16] == 8'h06 || frmData[23:16] == 8'h07)); // R2
  AST_FINE_PADDED: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && frmData[23:16] == 8'h07) |-> frmData[15:7] == 9'd0); // R4
  AST_FINE_THEN_COARSE: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && finePending) |-> frmData[23:16] == 8'h06); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && !frmReady) |=> (frmValid && $stable(frmData))); // R5
  AST_GAP_BETWEEN: assert property (@(posedge clk) disable iff (!rstN)
    (frmValid && finePending && !$past(frmValid)) |-> idleCnt == {1'b0, gapSeen}); // R6
  AST_GAP_AFTER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> idleCnt == {1'b0, gapSeen}); // R6
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busy && !frmValid)); // R7
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> frmValid); // R9
endmodule

bind dcxo_update_seq dcxo_seq_chk #(.GAP_W(GAP_W)) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .gapCycles (gapCycles),
  .frmValid  (frmValid),
  .frmReady  (frmReady),
  .frmData   (frmData),
  .busy      (busy)
);

// File: tb/dcxo_update_seq_test.sv
module dcxo_update_seq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWide = 1'b0;
  logic [22:0] reqValue = '0;
  logic [3:0]  devAddr = '0;
  logic [15:0] gapCycles = '0;
  logic        frmValid;
  logic        frmReady = 1'b0;
  logic [39:0] frmData;
  logic        busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dcxo_update_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWide(reqWide), .reqValue(reqValue), .devAddr(devAddr),
    .gapCycles(gapCycles), .frmValid(frmValid), .frmReady(frmReady),
    .frmData(frmData), .busy(busy)
  );

  function automatic logic [39:0] mkFrame(input logic [3:0] dev,
                                          input logic [7:0] regA,
                                          input logic [15:0] word);
    return {8'hFA, dev, 4'hA, regA, word};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic junkReq();
    reqValid  = 1'b1;
    reqWide   = 1'($urandom);
    reqValue  = 23'($urandom);
    devAddr   = 4'($urandom);
    gapCycles = 16'($urandom % 7);
  endtask

  task automatic runUpdate(input logic wide, input logic [22:0] val,
                           input logic [3:0] dev, input logic [15:0] gap,
                           input int stallPct);
    logic [39:0] expF [2];
    int nFrames;
    nFrames = wide ? 2 : 1;
    expF[0] = wide ? mkFrame(dev, 8'h07, {9'd0, val[6:0]})
                   : mkFrame(dev, 8'h06, val[15:0]);
    expF[1] = mkFrame(dev, 8'h06, val[22:7]);
    @(negedge clk);
    chk(reqReady && !busy, "R7 ready when idle", {62'd0, reqReady, busy}, 64'd2);
    reqValid = 1'b1; reqWide = wide; reqValue = val; devAddr = dev; gapCycles = gap;
    @(negedge clk);
    reqValid = 1'b0;
    reqValue = 23'($urandom); devAddr = 4'($urandom);
    gapCycles = 16'($urandom % 5); reqWide = 1'($urandom);
    chk(frmValid, "R9 valid after accept", {63'd0, frmValid}, 64'd1);
    for (int f = 0; f < nFrames; f++) begin
      int idle;
      bit first;
      bit acc;
      first = 1;
      forever begin
        if (first)
          chk(frmValid && frmData == expF[f], wide ? "R2 R4 frame" : "R2 R3 frame",
              {24'd0, frmData}, {24'd0, expF[f]});
        else
          chk(frmValid && frmData == expF[f], "R5 R8 held frame",
              {24'd0, frmData}, {24'd0, expF[f]});
        first = 0;
        acc = ($urandom % 100) >= 32'(stallPct);
        frmReady = acc;
        junkReq();
        chk(!reqReady, "R7 no ready while sending", {63'd0, reqReady}, 64'd0);
        @(negedge clk);
        frmReady = 1'b0;
        reqValid = 1'b0;
        if (acc) break;
      end
      idle = 0;
      while (busy && !frmValid && idle < 100000) begin
        chk(!reqReady, "R7 no ready in gap", {63'd0, reqReady}, 64'd0);
        junkReq();
        frmReady = 1'($urandom);
        @(negedge clk);
        idle++;
      end
      reqValid = 1'b0;
      frmReady = 1'b0;
      chk(idle == int'(gap), "R6 gap length", 64'(idle), 64'(gap));
      if (f < nFrames - 1)
        chk(frmValid, "R4 second frame follows", {63'd0, frmValid}, 64'd1);
      else
        chk(!busy && reqReady && !frmValid, "R6 idle after update",
            {61'd0, busy, reqReady, frmValid}, 64'd2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!frmValid && !busy && reqReady, "R1 reset state",
        {61'd0, frmValid, busy, reqReady}, 64'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(!frmValid && !busy && reqReady, "R1 after reset",
        {61'd0, frmValid, busy, reqReady}, 64'd1);
    // R4 worked values, positive and negative
    runUpdate(1'b1, 23'h09CF8A, 4'h0, 16'd3, 0);
    runUpdate(1'b1, 23'h5ECC0B, 4'h0, 16'd2, 40);
    // R3 narrow mode, upper bits must not leak, zero gap
    runUpdate(1'b0, 23'h7F1234, 4'h5, 16'd0, 0);
    // R6 wide with zero gap
    runUpdate(1'b1, 23'h400001, 4'hC, 16'd0, 50);
    runUpdate(1'b1, 23'h7FFFFF, 4'hF, 16'd1, 0);
    runUpdate(1'b0, 23'h008000, 4'h3, 16'd9, 70);
    for (int i = 0; i < 60; i++)
      runUpdate(1'($urandom), 23'($urandom), 4'($urandom), 16'($urandom % 6),
                int'($urandom % 60));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule